// File: doc/BRIEF.md
# Sensor Gate Pulse Generator

This block drives the eight vertical shift-gate lines of an interline image sensor. Each gate pulse moves the charge collected in the photosites into the shielded vertical registers, and so closes the exposure when no mechanical shutter is fitted. Four shared pulse shapes are held in the block. A shape is defined by a resting level and two pixel positions at which the level flips. Each gate output takes one of the four shapes and can be silenced on its own.

Timing comes from two single-cycle strobes on the pixel clock. A field-start strobe resets a line counter. A line-start strobe resets a pixel counter and advances the line counter. Pulses occur only on one programmed line of the field. All configuration inputs are captured into a shadow copy on the field-start strobe, so software may rewrite them at any time and a field never sees a mixture of old and new settings. There is no data stream, so every pin is a plain level or strobe.

Top module: `sgate_pulse_gen`

## Requirements
- R1: While reset is low, and after reset until the first field-start strobe, every gate output is 0, whatever the configuration inputs hold.
- R2: On the programmed line, an output shows its shape's resting level (bit s of `cfg_pol` for shape s) from the cycle after the line begins until its first flip.
- R3: On the programmed line, the shape's level inverts once when the pixel counter equals the first position and once when it equals the second position. The new level appears in the cycle after the matching count. The pixel counter reads 0 in the cycle after a strobe and then counts up by one per clock. Positions are 12-bit fields, with shape s at bits [12s+11:12s] of `cfg_tog1` and `cfg_tog2`.
- R4: When both positions of a shape are equal, the level inverts exactly once at that pixel.
- R5: On every line other than the programmed one, all outputs stay at their shapes' resting levels.
- R6: An output whose bit in `cfg_mask` is 1 stays at its shape's resting level for the whole field. A 0 bit lets the pulse through.
- R7: Output o follows the shape whose number is in bits [2o+1:2o] of `cfg_sel`, and several outputs may share one shape.
- R8: Configuration is taken only at a field-start strobe. Changes made during a field have no effect until the next field.
- R9: Every line-start strobe returns each shape to its resting level.
- R10: The line that begins with the field-start strobe is line 0, and each later line-start strobe adds one. A field-start strobe wins over a line-start strobe in the same cycle. `cfg_line` gives the line number on which pulses occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fld_strb | input | 1 | Field-start strobe, one cycle wide |
| ln_strb | input | 1 | Line-start strobe, one cycle wide |
| cfg_pol | input | 4 | Resting level for each shape |
| cfg_tog1 | input | 48 | First flip position for each shape, 12 bits per shape |
| cfg_tog2 | input | 48 | Second flip position for each shape, 12 bits per shape |
| cfg_line | input | 12 | Line within the field that carries the pulses |
| cfg_sel | input | 16 | Shape selector for each output, 2 bits per output |
| cfg_mask | input | 8 | Per-output suppress bits, 1 = suppressed |
| gate_out | output | 8 | Shift-gate outputs |

## Verification
The hardest case to reach from the ports is a configuration change in the middle of a field. The block must keep running the old settings on later lines, including the programmed line, while the inputs already hold different values. The stimulus walks a table of configurations field by field. One line into each field, it writes the next table entry onto the configuration inputs, so every pulse line after that is checked against the entry captured at the field start. The same walk covers a shape with equal flip positions, a pulse on line 0 where both strobes arrive together, fully masked fields, and a programmed line that never occurs.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
  localparam int DEF_NUM_OUT = 8;
  localparam int DEF_NUM_SEQ = 4;
  localparam int DEF_CNT_W   = 12;

  // width of an index able to address n entries (at least one bit)
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sgp_timebase.sv
module sgp_timebase #(
  parameter int CNT_W = sgp_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fld_strb,
  input  logic             ln_strb,
  output logic [CNT_W-1:0] px_cnt,
  output logic [CNT_W-1:0] ln_cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      px_cnt <= '0;
      ln_cnt <= '0;
    end else if (fld_strb) begin
      px_cnt <= '0;
      ln_cnt <= '0;
    end else if (ln_strb) begin
      px_cnt <= '0;
      ln_cnt <= ln_cnt + 1'b1;
    end else begin
      px_cnt <= px_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sgp_cfg_shadow.sv
module sgp_cfg_shadow #(
  parameter int NUM_OUT = sgp_pkg::DEF_NUM_OUT,
  parameter int NUM_SEQ = sgp_pkg::DEF_NUM_SEQ,
  parameter int CNT_W   = sgp_pkg::DEF_CNT_W,
  parameter int SEL_W   = sgp_pkg::idx_w(NUM_SEQ)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fld_strb,
  input  logic [NUM_SEQ-1:0]       pol_in,
  input  logic [NUM_SEQ*CNT_W-1:0] tog1_in,
  input  logic [NUM_SEQ*CNT_W-1:0] tog2_in,
  input  logic [CNT_W-1:0]         line_in,
  input  logic [NUM_OUT*SEL_W-1:0] sel_in,
  input  logic [NUM_OUT-1:0]       mask_in,
  output logic [NUM_SEQ-1:0]       pol_sh,
  output logic [NUM_SEQ*CNT_W-1:0] tog1_sh,
  output logic [NUM_SEQ*CNT_W-1:0] tog2_sh,
  output logic [CNT_W-1:0]         line_sh,
  output logic [NUM_OUT*SEL_W-1:0] sel_sh,
  output logic [NUM_OUT-1:0]       mask_sh,
  output logic                     armed
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_sh  <= '0;
      tog1_sh <= '0;
      tog2_sh <= '0;
      line_sh <= '0;
      sel_sh  <= '0;
      mask_sh <= '0;
      armed   <= 1'b0;
    end else if (fld_strb) begin
      pol_sh  <= pol_in;
      tog1_sh <= tog1_in;
      tog2_sh <= tog2_in;
      line_sh <= line_in;
      sel_sh  <= sel_in;
      mask_sh <= mask_in;
      armed   <= 1'b1;
    end
  end
endmodule

// File: rtl/sgp_seq_unit.sv
module sgp_seq_unit #(
  parameter int CNT_W = sgp_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fld_strb,
  input  logic             ln_strb,
  input  logic             pol_new,
  input  logic             pol_cur,
  input  logic             pulse_en,
  input  logic [CNT_W-1:0] px_cnt,
  input  logic [CNT_W-1:0] tog1,
  input  logic [CNT_W-1:0] tog2,
  output logic             lvl
);
  logic hit;

  // equal positions collapse into one flip
  assign hit = pulse_en && ((px_cnt == tog1) || (px_cnt == tog2));

  always_ff @(posedge clk) begin
    if (!rst_n)        lvl <= 1'b0;
    else if (fld_strb) lvl <= pol_new;
    else if (ln_strb)  lvl <= pol_cur;
    else if (hit)      lvl <= ~lvl;
  end
endmodule

// File: rtl/sgp_out_map.sv
module sgp_out_map #(
  parameter int NUM_OUT = sgp_pkg::DEF_NUM_OUT,
  parameter int NUM_SEQ = sgp_pkg::DEF_NUM_SEQ,
  parameter int SEL_W   = sgp_pkg::idx_w(NUM_SEQ)
) (
  input  logic [NUM_SEQ-1:0]       lvl,
  input  logic [NUM_SEQ-1:0]       pol_sh,
  input  logic [NUM_OUT*SEL_W-1:0] sel_sh,
  input  logic [NUM_OUT-1:0]       mask_sh,
  output logic [NUM_OUT-1:0]       gate
);
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [SEL_W-1:0] pick;
    assign pick    = sel_sh[o*SEL_W +: SEL_W];
    assign gate[o] = mask_sh[o] ? pol_sh[pick] : lvl[pick];
  end
endmodule

// File: rtl/sgate_pulse_gen.sv
module sgate_pulse_gen #(
  parameter int NUM_OUT = sgp_pkg::DEF_NUM_OUT,
  parameter int NUM_SEQ = sgp_pkg::DEF_NUM_SEQ,
  parameter int CNT_W   = sgp_pkg::DEF_CNT_W,
  localparam int SEL_W  = sgp_pkg::idx_w(NUM_SEQ)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fld_strb,
  input  logic                     ln_strb,
  input  logic [NUM_SEQ-1:0]       cfg_pol,
  input  logic [NUM_SEQ*CNT_W-1:0] cfg_tog1,
  input  logic [NUM_SEQ*CNT_W-1:0] cfg_tog2,
  input  logic [CNT_W-1:0]         cfg_line,
  input  logic [NUM_OUT*SEL_W-1:0] cfg_sel,
  input  logic [NUM_OUT-1:0]       cfg_mask,
  output logic [NUM_OUT-1:0]       gate_out
);
  logic [CNT_W-1:0]         px_q, ln_q;
  logic [NUM_SEQ-1:0]       pol_sh;
  logic [NUM_SEQ*CNT_W-1:0] tog1_sh, tog2_sh;
  logic [CNT_W-1:0]         line_sh;
  logic [NUM_OUT*SEL_W-1:0] sel_sh;
  logic [NUM_OUT-1:0]       mask_sh;
  logic                     armed;
  logic                     pulse_en;
  logic [NUM_SEQ-1:0]       lvl;

  sgp_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .fld_strb(fld_strb), .ln_strb(ln_strb),
    .px_cnt(px_q), .ln_cnt(ln_q)
  );

  sgp_cfg_shadow #(.NUM_OUT(NUM_OUT), .NUM_SEQ(NUM_SEQ), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .fld_strb(fld_strb),
    .pol_in(cfg_pol), .tog1_in(cfg_tog1), .tog2_in(cfg_tog2),
    .line_in(cfg_line), .sel_in(cfg_sel), .mask_in(cfg_mask),
    .pol_sh(pol_sh), .tog1_sh(tog1_sh), .tog2_sh(tog2_sh),
    .line_sh(line_sh), .sel_sh(sel_sh), .mask_sh(mask_sh), .armed(armed)
  );

  assign pulse_en = armed && (ln_q == line_sh);

  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
    sgp_seq_unit #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .fld_strb(fld_strb), .ln_strb(ln_strb),
      .pol_new(cfg_pol[s]), .pol_cur(pol_sh[s]), .pulse_en(pulse_en),
      .px_cnt(px_q),
      .tog1(tog1_sh[s*CNT_W +: CNT_W]), .tog2(tog2_sh[s*CNT_W +: CNT_W]),
      .lvl(lvl[s])
    );
  end

  sgp_out_map #(.NUM_OUT(NUM_OUT), .NUM_SEQ(NUM_SEQ), .SEL_W(SEL_W)) u_map (
    .lvl(lvl), .pol_sh(pol_sh), .sel_sh(sel_sh), .mask_sh(mask_sh), .gate(gate_out)
  );
endmodule

// File: rtl/sgp_chk.sv
module sgp_chk #(
  parameter int NUM_OUT = sgp_pkg::DEF_NUM_OUT,
  parameter int NUM_SEQ = sgp_pkg::DEF_NUM_SEQ,
  parameter int CNT_W   = sgp_pkg::DEF_CNT_W,
  parameter int SEL_W   = sgp_pkg::idx_w(NUM_SEQ)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     fld_strb,
  input logic                     ln_strb,
  input logic [NUM_OUT-1:0]       gate_out,
  input logic [CNT_W-1:0]         px_q,
  input logic [CNT_W-1:0]         ln_q,
  input logic [NUM_SEQ-1:0]       lvl,
  input logic [NUM_SEQ-1:0]       pol_sh,
  input logic [NUM_SEQ*CNT_W-1:0] tog1_sh,
  input logic [NUM_SEQ*CNT_W-1:0] tog2_sh,
  input logic [CNT_W-1:0]         line_sh,
  input logic [NUM_OUT*SEL_W-1:0] sel_sh,
  input logic [NUM_OUT-1:0]       mask_sh,
  input logic                     armed
);
  logic quiet;
  assign quiet = !fld_strb && !ln_strb;

  // R1
  reset_low_chk: assert property (@(posedge clk) !rst_n |=> gate_out == '0);

  // R1
  unarmed_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> gate_out == '0);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fld_strb |=> $stable({pol_sh, tog1_sh, tog2_sh, line_sh, sel_sh, mask_sh, armed}));

  // R5
  off_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && ln_q != line_sh) |=> $stable(lvl));

  // R9
  line_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ln_strb && !fld_strb) |=> lvl == pol_sh);

  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq_chk
    // R3
    no_stray_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && px_q != tog1_sh[s*CNT_W +: CNT_W] && px_q != tog2_sh[s*CNT_W +: CNT_W])
      |=> $stable(lvl[s]));
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out_chk
    // R6
    masked_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_sh[o] && !fld_strb) |=> $stable(gate_out[o]));
  end
endmodule

bind sgate_pulse_gen sgp_chk #(
  .NUM_OUT(NUM_OUT), .NUM_SEQ(NUM_SEQ), .CNT_W(CNT_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fld_strb(fld_strb), .ln_strb(ln_strb),
  .gate_out(gate_out), .px_q(px_q), .ln_q(ln_q), .lvl(lvl),
  .pol_sh(pol_sh), .tog1_sh(tog1_sh), .tog2_sh(tog2_sh), .line_sh(line_sh),
  .sel_sh(sel_sh), .mask_sh(mask_sh), .armed(armed)
);

// File: tb/test_sgate_pulse_gen.sv
`timescale 1ns/1ps
module test_sgate_pulse_gen;
  localparam int LL = 40;  // cycles per line
  localparam int NL = 4;   // lines per field

  typedef struct packed {
    logic [3:0]  pol;
    logic [47:0] t1;
    logic [47:0] t2;
    logic [11:0] line;
    logic [15:0] sel;
    logic [7:0]  mask;
  } vec_t;

  localparam int NV = 5;
  // shape s positions at [12s+:12]; selector of output o at [2o+:2]
  localparam vec_t VECS [NV] = '{
    // R4 R7: shape 1 has equal positions; outputs pick 0,1,2,3,0,1,2,3
    '{4'b0000, {12'd20, 12'd3, 12'd10, 12'd5}, {12'd25, 12'd30, 12'd10, 12'd15},
      12'd2, {2'd3, 2'd2, 2'd1, 2'd0, 2'd3, 2'd2, 2'd1, 2'd0}, 8'h00},
    // R10 R6 R4: pulses on line 0, partial mask, shape 3 equal positions
    '{4'b1010, {12'd12, 12'd38, 12'd7, 12'd0}, {12'd12, 12'd0, 12'd7, 12'd38},
      12'd0, {2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3}, 8'hA5},
    // R7 R2: all outputs share shape 2, last line of field
    '{4'b1111, {12'd8, 12'd4, 12'd2, 12'd1}, {12'd30, 12'd9, 12'd17, 12'd33},
      12'd3, 16'hAAAA, 8'h00},
    // R6: every output masked
    '{4'b0101, {12'd6, 12'd6, 12'd6, 12'd6}, {12'd9, 12'd9, 12'd9, 12'd9},
      12'd1, 16'h1B1B, 8'hFF},
    // R5: programmed line never reached
    '{4'b0011, {12'd2, 12'd4, 12'd6, 12'd8}, {12'd20, 12'd22, 12'd24, 12'd26},
      12'hFFF, 16'hE4E4, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fld_strb, ln_strb;
  logic [3:0]  cfg_pol;
  logic [47:0] cfg_tog1, cfg_tog2;
  logic [11:0] cfg_line;
  logic [15:0] cfg_sel;
  logic [7:0]  cfg_mask;
  logic [7:0]  gate_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sgate_pulse_gen i_sgate_pulse_gen (
    .clk(clk), .rst_n(rst_n), .fld_strb(fld_strb), .ln_strb(ln_strb),
    .cfg_pol(cfg_pol), .cfg_tog1(cfg_tog1), .cfg_tog2(cfg_tog2),
    .cfg_line(cfg_line), .cfg_sel(cfg_sel), .cfg_mask(cfg_mask),
    .gate_out(gate_out)
  );

  task automatic apply(input vec_t v);
    cfg_pol  = v.pol;
    cfg_tog1 = v.t1;
    cfg_tog2 = v.t2;
    cfg_line = v.line;
    cfg_sel  = v.sel;
    cfg_mask = v.mask;
  endtask

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %b exp %b", what, got, exp);
    end
  endtask

  // expected level: resting level, inverted once per distinct position already passed
  function automatic logic [7:0] expect_gate(input vec_t e, input int line, input int pix);
    logic [7:0] r;
    for (int o = 0; o < 8; o++) begin
      int s = int'(e.sel[o*2 +: 2]);
      int a = int'(e.t1[s*12 +: 12]);
      int b = int'(e.t2[s*12 +: 12]);
      int n = 0;
      if (!e.mask[o] && line == int'(e.line)) begin
        if (a < pix) n++;
        if (b < pix && b != a) n++;
      end
      r[o] = e.pol[s] ^ n[0];
    end
    return r;
  endfunction

  // one field; inputs change to nxt at the start of line 1 (R8)
  task automatic run_field(input vec_t e, input vec_t nxt, input string tag);
    for (int line = 0; line < NL; line++) begin
      for (int c = 0; c < LL; c++) begin
        fld_strb = (line == 0 && c == 0);
        ln_strb  = (c == 0);  // coincides with the field strobe on line 0 (R10)
        if (line == 1 && c == 0) apply(nxt);
        @(posedge clk);
        @(negedge clk);
        fld_strb = 1'b0;
        ln_strb  = 1'b0;
        begin
          string rq;
          if (line == int'(e.line)) rq = (c == 0) ? "R2" : "R3";
          else if (line == int'(e.line) + 1) rq = "R9";
          else rq = "R5";
          check(gate_out, expect_gate(e, line, c),
                $sformatf("%s %s R8 line %0d pix %0d", rq, tag, line, c));
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    fld_strb = 1'b0;
    ln_strb  = 1'b0;
    apply(VECS[2]);  // resting level 1 on the inputs, not yet captured
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(gate_out, 8'h00, "R1 during reset");
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      if (i == 4) ln_strb = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ln_strb = 1'b0;
      if (i % 4 == 3) check(gate_out, 8'h00, $sformatf("R1 before first field, cycle %0d", i));
    end

    apply(VECS[0]);
    for (int k = 0; k < NV; k++) begin
      string tg;
      case (k)
        0: tg = "R4 R7";
        1: tg = "R10 R6 R4";
        2: tg = "R7";
        3: tg = "R6";
        default: tg = "R5";
      endcase
      run_field(VECS[k], VECS[(k + 1) % NV], tg);
    end

    // R9: pulse line with late strobe on line 0 only; the next field still uses VECS[0]
    run_field(VECS[0], VECS[1], "R9 R3 repeat");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule